// File: doc/BRIEF.md
# Wave Cross-Lane Operation Unit

This block performs one cross-lane operation across all lanes of a SIMD wave in a single issue. Each lane presents a data word and a source-lane index. The wave supplies an active-lane mask and a 4-bit operation select. The unit returns one result word per lane, registered, together with a valid strobe. The register file, instruction decode and scheduling lie outside this block.

The operations are grouped under one select field. Broadcast copies lane 0 to every lane. Three whole-wave reductions give the sum, the signed minimum and the signed maximum. An exclusive scan adds up the lanes below each lane. Shuffle reads another lane's value by index. Three vote operations give a ballot bitmap, any-nonzero and all-nonzero. The active mask governs every operation. An inactive lane adds nothing to a combination, and its own result is zero. An unused select value produces zero results and raises an illegal flag.

The combining logic is flat, with a single register at the output. The latency is therefore one clock for every operation.

Top module: `wave_xlane_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high for the following cycle, and the results belong to that issue. When `in_valid` is low, `out_valid` is low in the following cycle.
- R2: Every lane whose bit in `in_mask` was 0 at issue has a zero result, whatever the operation.
- R3: Select 0 (broadcast): every active lane receives lane 0's input word. This holds even when lane 0 is itself inactive.
- R4: Select 1 (sum): every active lane receives the sum of the words of all active lanes, modulo 2^DW.
- R5: Select 2 (minimum) and select 3 (maximum): every active lane receives the smallest or the largest active word, compared as two's-complement signed values.
- R6: Select 4 (exclusive scan): active lane i receives the sum, modulo 2^DW, of the words of the active lanes with index below i. Lane 0 receives 0.
- R7: Select 5 (shuffle): active lane i receives the word of lane k. Here k is the low log2(LANES) bits of lane i's `in_src` field. If lane k is inactive, the result is 0.
- R8: Select 6 (ballot): every active lane receives a word whose bit j is 1 exactly when lane j is active and its word is nonzero. All higher bits are 0.
- R9: Select 7 (any) gives 1 when at least one active lane holds a nonzero word, and 0 otherwise. Select 8 (all) gives 0 when some active lane holds zero, and 1 otherwise. Inactive lanes never affect either vote. Each vote is written to every active lane.
- R10: Select values 9 to 15 give all-zero results, with `out_illegal` high alongside `out_valid`. For a legal select, `out_illegal` is low.
- R11: After reset, all outputs are zero. While `in_valid` is low, `out_data` keeps its last value and `out_illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for one operation |
| in_mod | input | 4 | Operation select |
| in_mask | input | LANES | Active-lane mask, bit i for lane i |
| in_data | input | LANES*DW | Lane words, lane i at bits [i*DW +: DW] |
| in_src | input | LANES*SRCW | Source-lane index per lane, lane i at bits [i*SRCW +: SRCW] |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| out_illegal | output | 1 | Unused select value seen at issue |
| out_data | output | LANES*DW | Lane results, lane i at bits [i*DW +: DW] |

## Verification
The bench builds the unit with LANES=4, DW=8 and SRCW=8. This makes a full sweep affordable: all 16 select values against all 16 active masks, each with several mixed data sets. The data sets include zero lanes, negative bytes and values that wrap past 255. Because of this, the sum and scan wraparound, the signed extremes and every partial-mask case of the votes are all visible on 8-bit words. Index bits above the low two are set freely, so the index truncation of the shuffle is also exercised.

// File: rtl/wxl_pkg.sv
package wxl_pkg;

  typedef enum logic [3:0] {
    OP_BCAST   = 4'd0,
    OP_RSUM    = 4'd1,
    OP_RMIN    = 4'd2,
    OP_RMAX    = 4'd3,
    OP_XSCAN   = 4'd4,
    OP_SHFL    = 4'd5,
    OP_VMASK   = 4'd6,
    OP_VANY    = 4'd7,
    OP_VALL    = 4'd8
  } wxl_op_e;

  localparam int unsigned MOD_W = 4;

  function automatic logic mod_is_legal(input logic [MOD_W-1:0] m);
    return m <= 4'd8;
  endfunction

endpackage

// File: rtl/wxl_reduce.sv
module wxl_reduce #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32
) (
  input  logic [LANES*DW-1:0] data,
  input  logic [LANES-1:0]    mask,
  output logic [DW-1:0]       sum,
  output logic [DW-1:0]       smin,
  output logic [DW-1:0]       smax,
  output logic [LANES-1:0]    nz,
  output logic                any_nz,
  output logic                all_nz
);

  localparam logic [DW-1:0] POS_TOP = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_BOT = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] pick_min(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return ($signed(b) < $signed(a)) ? b : a;
  endfunction

  function automatic logic [DW-1:0] pick_max(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return ($signed(b) > $signed(a)) ? b : a;
  endfunction

  always_comb begin
    logic [DW-1:0] v;
    sum  = '0;
    smin = POS_TOP;
    smax = NEG_BOT;
    nz   = '0;
    for (int i = 0; i < LANES; i++) begin
      v = data[i*DW +: DW];
      nz[i] = mask[i] && (v != '0);
      if (mask[i]) begin
        sum  = sum + v;
        smin = pick_min(smin, v);
        smax = pick_max(smax, v);
      end
    end
    any_nz = |nz;
    all_nz = (nz == mask);
  end

endmodule

// File: rtl/wxl_scan.sv
module wxl_scan #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32
) (
  input  logic [LANES*DW-1:0] data,
  input  logic [LANES-1:0]    mask,
  output logic [LANES*DW-1:0] prefix
);

  always_comb begin
    logic [DW-1:0] acc;
    acc    = '0;
    prefix = '0;
    for (int i = 0; i < LANES; i++) begin
      prefix[i*DW +: DW] = acc;
      if (mask[i]) acc = acc + data[i*DW +: DW];
    end
  end

endmodule

// File: rtl/wxl_shuffle.sv
module wxl_shuffle #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned SRCW  = 32
) (
  input  logic [LANES*DW-1:0]   data,
  input  logic [LANES-1:0]      mask,
  input  logic [LANES*SRCW-1:0] src,
  output logic [LANES*DW-1:0]   pulled
);

  localparam int unsigned IDXW = (LANES > 1) ? $clog2(LANES) : 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDXW-1:0] idx;
    assign idx = src[g*SRCW +: IDXW];
    assign pulled[g*DW +: DW] = mask[idx] ? data[idx*DW +: DW] : '0;
  end

endmodule

// File: rtl/wave_xlane_unit.sv
module wave_xlane_unit #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned SRCW  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [3:0]            in_mod,
  input  logic [LANES-1:0]      in_mask,
  input  logic [LANES*DW-1:0]   in_data,
  input  logic [LANES*SRCW-1:0] in_src,
  output logic                  out_valid,
  output logic                  out_illegal,
  output logic [LANES*DW-1:0]   out_data
);

  import wxl_pkg::*;

  logic [DW-1:0]       sum_w, min_w, max_w;
  logic [LANES-1:0]    nz_w;
  logic                any_w, all_w;
  logic [LANES*DW-1:0] scan_w, shfl_w, res_w;
  logic                illegal_w;

  wxl_reduce #(.LANES(LANES), .DW(DW)) reduce_i (
    .data(in_data), .mask(in_mask), .sum(sum_w), .smin(min_w), .smax(max_w),
    .nz(nz_w), .any_nz(any_w), .all_nz(all_w)
  );

  wxl_scan #(.LANES(LANES), .DW(DW)) scan_i (
    .data(in_data), .mask(in_mask), .prefix(scan_w)
  );

  wxl_shuffle #(.LANES(LANES), .DW(DW), .SRCW(SRCW)) shfl_i (
    .data(in_data), .mask(in_mask), .src(in_src), .pulled(shfl_w)
  );

  assign illegal_w = !mod_is_legal(in_mod);

  always_comb begin
    logic [DW-1:0] v;
    res_w = '0;
    for (int i = 0; i < LANES; i++) begin
      case (wxl_op_e'(in_mod))
        OP_BCAST: v = in_data[DW-1:0];
        OP_RSUM:  v = sum_w;
        OP_RMIN:  v = min_w;
        OP_RMAX:  v = max_w;
        OP_XSCAN: v = scan_w[i*DW +: DW];
        OP_SHFL:  v = shfl_w[i*DW +: DW];
        OP_VMASK: v = DW'(nz_w);
        OP_VANY:  v = DW'(any_w);
        OP_VALL:  v = DW'(all_w);
        default:  v = '0;
      endcase
      res_w[i*DW +: DW] = (in_mask[i] && !illegal_w) ? v : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && illegal_w;
      if (in_valid) out_data <= res_w;
    end
  end

endmodule

// File: rtl/wxl_checker.sv
module wxl_checker #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [3:0]          in_mod,
  input logic [LANES-1:0]    in_mask,
  input logic [LANES*DW-1:0] in_data,
  input logic                out_valid,
  input logic                out_illegal,
  input logic [LANES*DW-1:0] out_data,
  input logic                illegal_w
);

  logic [LANES*DW-1:0] mask_x;
  for (genvar g = 0; g < LANES; g++) begin : g_mx
    assign mask_x[g*DW +: DW] = {DW{in_mask[g]}};
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_inactive_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_data & ~$past(mask_x)) == '0));

  assert_bcast_lane0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mod == 4'd0 && in_mask[0]) |=> (out_data[DW-1:0] == $past(in_data[DW-1:0])));

  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && illegal_w) |=> (out_illegal && out_data == '0));

  assert_illegal_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && !out_illegal));

endmodule

bind wave_xlane_unit wxl_checker #(.LANES(LANES), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mod(in_mod),
  .in_mask(in_mask), .in_data(in_data), .out_valid(out_valid),
  .out_illegal(out_illegal), .out_data(out_data), .illegal_w(illegal_w)
);

// File: tb/wave_xlane_unit_tb.sv
module wave_xlane_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int SRCW  = 8;
  localparam int NPAT  = 6;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic [3:0]            in_mod = '0;
  logic [LANES-1:0]      in_mask = '0;
  logic [LANES*DW-1:0]   in_data = '0;
  logic [LANES*SRCW-1:0] in_src = '0;
  logic                  out_valid, out_illegal;
  logic [LANES*DW-1:0]   out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_xlane_unit #(.LANES(LANES), .DW(DW), .SRCW(SRCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mod(in_mod),
    .in_mask(in_mask), .in_data(in_data), .in_src(in_src),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data)
  );

  function automatic int unsigned next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic string req_of(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      7, 8: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Expected lane word, computed arithmetically from the requirements
  function automatic int expect_lane(int m, int mask, int d[LANES], int s[LANES], int i);
    int r = 0;
    int sv;
    if (((mask >> i) & 1) == 0) return 0;          // R2
    case (m)
      0: r = d[0];
      1: begin for (int j = 0; j < LANES; j++) if ((mask >> j) & 1) r += d[j]; end
      2: begin
        r = 127;
        for (int j = 0; j < LANES; j++) if ((mask >> j) & 1) begin
          sv = (d[j] >= 128) ? d[j] - 256 : d[j];
          if (sv < r) r = sv;
        end
      end
      3: begin
        r = -128;
        for (int j = 0; j < LANES; j++) if ((mask >> j) & 1) begin
          sv = (d[j] >= 128) ? d[j] - 256 : d[j];
          if (sv > r) r = sv;
        end
      end
      4: begin for (int j = 0; j < i; j++) if ((mask >> j) & 1) r += d[j]; end
      5: begin
        sv = s[i] % LANES;
        r = ((mask >> sv) & 1) ? d[sv] : 0;
      end
      6: begin for (int j = 0; j < LANES; j++) if (((mask >> j) & 1) && d[j] != 0) r += (1 << j); end
      7: begin for (int j = 0; j < LANES; j++) if (((mask >> j) & 1) && d[j] != 0) r = 1; end
      8: begin r = 1; for (int j = 0; j < LANES; j++) if (((mask >> j) & 1) && d[j] == 0) r = 0; end
      default: r = 0;
    endcase
    return r & 255;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vector(int m, int mask, int p);
    int d[LANES];
    int s[LANES];
    int exp;
    logic [LANES*DW-1:0] held;
    for (int i = 0; i < LANES; i++) begin
      d[i] = next_rand() & 255;
      if (((d[i] >> 3) & 3) == 0 || (p == 0 && i == 1)) d[i] = 0;
      if (p == 1) d[i] = 200 + i;                   // wraps the 8-bit sum
      s[i] = next_rand() & 255;                     // high index bits set freely
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_mod   = 4'(m);
    in_mask  = LANES'(mask);
    for (int i = 0; i < LANES; i++) begin
      in_data[i*DW +: DW] = DW'(d[i]);
      in_src[i*SRCW +: SRCW] = SRCW'(s[i]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "out_valid after issue", int'(out_valid), 1);
    check("R10", "illegal flag", int'(out_illegal), (m > 8) ? 1 : 0);
    for (int i = 0; i < LANES; i++) begin
      exp = expect_lane(m, mask, d, s, i);
      check(((mask >> i) & 1) ? req_of(m) : "R2", $sformatf("mod %0d mask %0h lane %0d", m, mask, i),
            int'(out_data[i*DW +: DW]), exp);
    end
    held = out_data;
    in_mod  = 4'(next_rand() & 15);
    in_mask = LANES'(next_rand());
    in_data = LANES*DW'(next_rand());
    @(negedge clk);
    check("R11", "data hold while idle", (out_data == held) ? 1 : 0, 1);
    check("R1", "out_valid idle", int'(out_valid), 0);
    check("R11", "illegal low while idle", int'(out_illegal), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "reset out_valid", int'(out_valid), 0);
    check("R11", "reset out_illegal", int'(out_illegal), 0);
    check("R11", "reset out_data", (out_data == '0) ? 1 : 0, 1);
    rst_n = 1'b1;
    for (int m = 0; m < 16; m++)
      for (int mask = 0; mask < 16; mask++)
        for (int p = 0; p < NPAT; p++)
          run_vector(m, mask, p);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule